// File: doc/BRIEF.md
# Write Burst Beat Address and Lane Mask Generator

This block turns one write burst request into a sequence of data beats for a 64-bit (8-lane) data bus. For every beat it presents the beat address and the byte-lane enable mask that a write data channel needs. A request carries a start address, a beat count, a transfer size of 1, 2, 4 or 8 bytes, and a burst kind: fixed, incrementing or wrapping. Incrementing and fixed bursts may start at any byte address. A wrapping burst with an unaligned start, or with an illegal beat count, is refused and reported on an error output.

The controller is a three-state machine. `ST_IDLE` waits for a request and holds `req_ready` high. On an accepted request it takes transition `GO_RUN` to `ST_RUN` if the request is legal, or `GO_REJECT` to `ST_REJECT` if it is not. `ST_RUN` presents one beat per cycle and moves on only when `beat_valid` and `beat_ready` are both high. When the final beat is accepted it takes `RUN_DONE` back to `ST_IDLE`. `ST_REJECT` raises `req_err` for exactly one cycle and then takes `REJECT_DONE` back to `ST_IDLE`. The request fields are captured when the request is accepted and do not change until the burst ends.

Top module: `wburst_beat_gen`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `beat_valid`=0, `req_err`=0.
- R2: A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` is high only in the idle state, so it stays low while a burst runs and while a refusal is reported.
- R3: Field encodings: `req_kind` 0 = fixed, 1 = incrementing, 2 = wrapping, 3 = reserved (always refused). `req_size` is log2 of the bytes per beat (0..3). `req_len` is the number of beats minus one.
- R4: For an incrementing burst, beat 0 is at the start address. Beat n (n>=1) is at the start address rounded down to a multiple of the size, plus n times the size. Example: size 4, start 0x001, 4 beats gives 0x001, 0x004, 0x008, 0x00C.
- R5: Bit i of `beat_strb` enables byte lane i. The mask covers every lane from the beat address's low 3 bits up to the last byte of the size-aligned chunk that holds that address. Example: size 4 at 0x001 gives 8'b0000_1110. Size 4 at 0x004 gives 8'b1111_0000.
- R6: In a fixed burst, every beat carries the start address and the same lane mask.
- R7: A wrapping burst needs a start aligned to the size and a `req_len` of 1, 3, 7 or 15. Its addresses step by the size and fall back to the start rounded down to (size x beats) when they reach that boundary.
- R8: A wrapping request with an unaligned start or an illegal length, and any reserved-kind request, produces no beats. `req_err` is high for exactly the one cycle after acceptance, and the block is idle in the cycle after that.
- R9: The beat index advances only on a cycle with `beat_valid` and `beat_ready` both high. While `beat_ready` is low, the address, mask and last flag hold.
- R10: `beat_last` is high on the final beat only. After that beat is accepted, the next cycle is idle with `beat_valid`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Block can take a request (idle) |
| req_addr | input | ADDR_W | Burst start address |
| req_len | input | LEN_W | Beats minus one |
| req_size | input | 2 | log2 of bytes per beat |
| req_kind | input | 2 | Burst kind code |
| req_err | output | 1 | One-cycle refusal pulse |
| beat_valid | output | 1 | A beat is presented |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_addr | output | ADDR_W | Address of the current beat |
| beat_strb | output | LANES | Byte-lane enable mask |
| beat_last | output | 1 | Current beat is the final one |

## Verification
The assertions assume that the request fields are sampled only on the accepting cycle. They also assume that `req_size` never exceeds the bus width, so a captured size always describes 1 to 8 lanes. They assume the consumer may drop `beat_ready` at any time. The stimulus drives fields only together with `req_valid` in the idle state and sweeps sizes 0 to 3 only. It drops `beat_ready` on a fixed cadence, so that stall cycles land on first, middle and last beats.

// File: rtl/wburst_pkg.sv
package wburst_pkg;

    typedef enum logic [1:0] {
        BK_FIXED = 2'd0,
        BK_INCR  = 2'd1,
        BK_WRAP  = 2'd2,
        BK_RSVD  = 2'd3
    } burst_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_REJECT = 2'd2
    } gen_state_e;

endpackage

// File: rtl/wburst_lane_mask.sv
module wburst_lane_mask #(
    parameter int LANES  = 8,
    parameter int OFF_W  = $clog2(LANES),
    parameter int SIZE_W = 2
) (
    input  logic [OFF_W-1:0]  lane_off,
    input  logic [SIZE_W-1:0] size,
    output logic [LANES-1:0]  mask
);
    logic [OFF_W:0]   nbytes;
    logic [OFF_W-1:0] low_mask;
    logic [OFF_W-1:0] chunk_base;
    logic [OFF_W-1:0] chunk_top;

    always_comb begin
        nbytes     = {{OFF_W{1'b0}}, 1'b1} << size;
        low_mask   = nbytes[OFF_W-1:0] - OFF_W'(1);
        chunk_base = lane_off & ~low_mask;
        chunk_top  = chunk_base | low_mask;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask[i] = (OFF_W'(i) >= lane_off) && (OFF_W'(i) <= chunk_top);
    end

endmodule

// File: rtl/wburst_addr_step.sv
module wburst_addr_step
    import wburst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 2
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [SIZE_W-1:0] size,
    input  burst_kind_e       kind,
    input  logic [ADDR_W-1:0] wrap_lo,
    input  logic [ADDR_W-1:0] wrap_span,
    output logic [ADDR_W-1:0] nxt_addr
);
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] aligned_inc;
    logic [ADDR_W-1:0] plain_inc;

    always_comb begin
        step        = ADDR_W'(1) << size;
        aligned_inc = (cur_addr & ~(step - ADDR_W'(1))) + step;
        plain_inc   = cur_addr + step;
        unique case (kind)
            BK_FIXED: nxt_addr = cur_addr;
            BK_INCR:  nxt_addr = aligned_inc;
            BK_WRAP:  nxt_addr = (plain_inc == wrap_lo + wrap_span) ? wrap_lo : plain_inc;
            default:  nxt_addr = cur_addr;
        endcase
    end

endmodule

// File: rtl/wburst_beat_gen.sv
module wburst_beat_gen
    import wburst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [1:0]        req_size,
    input  logic [1:0]        req_kind,
    output logic              req_err,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [LANES-1:0]  beat_strb,
    output logic              beat_last
);
    localparam int OFF_W  = $clog2(LANES);
    localparam int SIZE_W = 2;

    gen_state_e        state_q, state_d;
    burst_kind_e       kind_in;
    burst_kind_e       kind_q;
    logic [SIZE_W-1:0] size_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wrap_lo_q;
    logic [ADDR_W-1:0] span_q;
    logic [ADDR_W-1:0] nxt_addr;

    logic              take_req;
    logic              take_beat;
    logic              is_last;
    logic              req_bad;
    logic [ADDR_W-1:0] span_c;
    logic [ADDR_W-1:0] size_lo_mask;
    logic              wrap_len_ok;

    assign kind_in   = burst_kind_e'(req_kind);
    assign take_req  = req_valid && req_ready;
    assign take_beat = beat_valid && beat_ready;
    assign is_last   = (cnt_q == len_q);

    // Request legality check
    always_comb begin
        span_c       = (ADDR_W'(req_len) + ADDR_W'(1)) << req_size;
        size_lo_mask = (ADDR_W'(1) << req_size) - ADDR_W'(1);
        wrap_len_ok  = (req_len == LEN_W'(1)) || (req_len == LEN_W'(3)) ||
                       (req_len == LEN_W'(7)) || (req_len == LEN_W'(15));
        req_bad      = 1'b0;
        if (32'(req_size) > OFF_W) begin
            req_bad = 1'b1;
        end
        unique case (kind_in)
            BK_RSVD: req_bad = 1'b1;
            BK_WRAP: if (((req_addr & size_lo_mask) != '0) || !wrap_len_ok) req_bad = 1'b1;
            default: ;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take_req) state_d = req_bad ? ST_REJECT : ST_RUN;
            ST_RUN:    if (take_beat && is_last) state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Burst context and beat tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q    <= BK_FIXED;
            size_q    <= '0;
            len_q     <= '0;
            cnt_q     <= '0;
            addr_q    <= '0;
            wrap_lo_q <= '0;
            span_q    <= '0;
        end else if (take_req) begin
            kind_q    <= kind_in;
            size_q    <= req_size;
            len_q     <= req_len;
            cnt_q     <= '0;
            addr_q    <= req_addr;
            wrap_lo_q <= req_addr & ~(span_c - ADDR_W'(1));
            span_q    <= span_c;
        end else if (take_beat && !is_last) begin
            cnt_q  <= cnt_q + LEN_W'(1);
            addr_q <= nxt_addr;
        end
    end

    wburst_addr_step #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_step (
        .cur_addr  (addr_q),
        .size      (size_q),
        .kind      (kind_q),
        .wrap_lo   (wrap_lo_q),
        .wrap_span (span_q),
        .nxt_addr  (nxt_addr)
    );

    wburst_lane_mask #(.LANES(LANES), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_mask (
        .lane_off (addr_q[OFF_W-1:0]),
        .size     (size_q),
        .mask     (beat_strb)
    );

    // Outputs from state
    always_comb begin
        req_ready  = 1'b0;
        req_err    = 1'b0;
        beat_valid = 1'b0;
        beat_last  = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_RUN: begin
                beat_valid = 1'b1;
                beat_last  = is_last;
            end
            ST_REJECT: req_err = 1'b1;
            default: ;
        endcase
    end

    assign beat_addr = addr_q;

endmodule

// File: rtl/wburst_beat_gen_chk.sv
module wburst_beat_gen_chk #(
    parameter int ADDR_W = 16,
    parameter int LANES  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_size,
    input logic [1:0]        req_kind,
    input logic              req_err,
    input logic              beat_valid,
    input logic              beat_ready,
    input logic [ADDR_W-1:0] beat_addr,
    input logic [LANES-1:0]  beat_strb,
    input logic              beat_last
);
    logic [1:0] kind_c;
    logic [1:0] size_c;
    logic       first_c;
    logic [ADDR_W-1:0] align_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_c  <= '0;
            size_c  <= '0;
            first_c <= 1'b0;
        end else if (req_valid && req_ready) begin
            kind_c  <= req_kind;
            size_c  <= req_size;
            first_c <= 1'b1;
        end else if (beat_valid && beat_ready) begin
            first_c <= 1'b0;
        end
    end

    assign align_c = (ADDR_W'(1) << size_c) - ADDR_W'(1);

    // R2
    no_ready_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (beat_valid || req_err)));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) &&
        $stable(beat_strb) && $stable(beat_last));

    // R10
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && beat_last |=> !beat_valid && req_ready);

    // R6
    fixed_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && !beat_last && kind_c == 2'd0 |=>
        beat_addr == $past(beat_addr) && beat_strb == $past(beat_strb));

    // R4
    incr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !first_c && kind_c == 2'd1 |-> (beat_addr & align_c) == '0);

    // R5
    strb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> beat_strb != '0 && $countones(beat_strb) <= (1 << size_c));

    // R8
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> !req_err && req_ready && !beat_valid);

endmodule

bind wburst_beat_gen wburst_beat_gen_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_size   (req_size),
    .req_kind   (req_kind),
    .req_err    (req_err),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_addr  (beat_addr),
    .beat_strb  (beat_strb),
    .beat_last  (beat_last)
);

// File: tb/tb_wburst_beat_gen.sv
module tb_wburst_beat_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic [1:0]  req_size = '0;
    logic [1:0]  req_kind = '0;
    logic        req_err;
    logic        beat_valid;
    logic        beat_ready = 1'b0;
    logic [15:0] beat_addr;
    logic [7:0]  beat_strb;
    logic        beat_last;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int tick  = 0;

    always #10 clk = ~clk;

    wburst_beat_gen dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_size(req_size), .req_kind(req_kind),
        .req_err(req_err), .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_addr(beat_addr), .beat_strb(beat_strb), .beat_last(beat_last)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_addr(int kind, int size, int start, int len, int n);
        int bytes = 1 << size;
        int span  = bytes * (len + 1);
        int lo;
        if (kind == 0) return 16'(start);
        if (kind == 1) return (n == 0) ? 16'(start) : 16'((start / bytes) * bytes + n * bytes);
        lo = (start / span) * span;
        return 16'(lo + ((start - lo) + n * bytes) % span);
    endfunction

    function automatic logic [7:0] exp_strb(int size, int a);
        int bytes = 1 << size;
        int top   = (a / bytes) * bytes + bytes - 1;
        logic [7:0] m = '0;
        for (int b = a; b <= top; b++) m[b % 8] = 1'b1;
        return m;
    endfunction

    task automatic do_burst(input int kind, input int size, input int start, input int len);
        bit is_err;
        int n;
        logic [15:0] ea;
        bit stall;
        is_err = (kind == 3) ||
                 (kind == 2 && ((start % (1 << size)) != 0 ||
                  !(len == 1 || len == 3 || len == 7 || len == 15)));
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 idle ready", 32'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = 16'(start);
        req_len   = 8'(len);
        req_size  = 2'(size);
        req_kind  = 2'(kind);
        @(negedge clk);
        req_valid = 1'b0;
        if (is_err) begin
            chk(req_err && !beat_valid && !req_ready, "R8 refusal pulse",
                {29'b0, req_err, beat_valid, req_ready}, 32'b100);
            @(negedge clk);
            chk(!req_err && req_ready && !beat_valid, "R8 back to idle",
                {29'b0, req_err, beat_valid, req_ready}, 32'b001);
            return;
        end
        n = 0;
        while (n <= len) begin
            stall = (tick % 3 == 2);
            tick++;
            beat_ready = !stall;
            ea = exp_addr(kind, size, start, len, n);
            chk(beat_valid && !req_ready, "R2 busy", {30'b0, beat_valid, req_ready}, 32'b10);
            if (kind == 0) chk(beat_addr == ea, "R6 fixed addr", 32'(beat_addr), 32'(ea));
            else if (kind == 1) chk(beat_addr == ea, "R4 incr addr", 32'(beat_addr), 32'(ea));
            else chk(beat_addr == ea, "R7 wrap addr", 32'(beat_addr), 32'(ea));
            chk(beat_strb == exp_strb(size, int'(ea)), "R5 lane mask",
                32'(beat_strb), 32'(exp_strb(size, int'(ea))));
            chk(beat_last == (n == len), "R10 last flag", 32'(beat_last), 32'(n == len));
            @(negedge clk);
            if (!stall) n++;
            else chk(beat_valid && beat_addr == ea, "R9 stall hold", 32'(beat_addr), 32'(ea));
        end
        beat_ready = 1'b0;
        chk(!beat_valid && req_ready, "R10 idle after last", {30'b0, beat_valid, req_ready}, 32'b01);
    endtask

    initial begin
        int lens[6] = '{0, 1, 2, 3, 7, 15};
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && beat_valid == 1'b0 && req_err == 1'b0, "R1 reset state",
            {29'b0, req_ready, beat_valid, req_err}, 32'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && beat_valid == 1'b0, "R1 after release",
            {30'b0, req_ready, beat_valid}, 32'b10);
        // R4 R5 example: size 4 from 0x001, four beats
        do_burst(1, 2, 1, 3);
        // R3 sweep over all kind codes, sizes, offsets and lengths
        for (int k = 0; k < 4; k++)
            for (int s = 0; s < 4; s++)
                for (int off = 0; off < 16; off++)
                    for (int li = 0; li < 6; li++)
                        do_burst(k, s, 16'h00F8 + off, lens[li]);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule